// File: doc/BRIEF.md
# Extension-Slot Request Scheduler

This block decides which of `NCTRL` bus controllers transmits in each slot of the variable-length extension part of a time-division communication cycle. Each controller may ask for at most one extra slot per cycle. The agreed request vector arrives once per cycle with a three-valued code per controller: request, no request or unknown. A `merge` strobe folds this vector into a register of pending requests. Requests that are not served in the current cycle stay pending for later cycles.

Before each extension slot, a `select` strobe asks the block for the next controller. The winner is presented on `grant_idx` with `grant_valid` set. After the slot, an `adjust` strobe retires that request and moves the rotating index register one position past the winner. The number of grants between two merges is capped at `EXT_SLOTS`.

The ordering rule is a parameter:
- FIFO: rotating scan from the index register.
- Static priority: lowest index first.
- Priority-first: an urgent class of low-index controllers is served by priority, and the rest by rotation.
- FIFO-first: the rotating class is served first, and the urgent class only when the rotating class is empty.

A three-state controller sequences the strobes:
- `ST_IDLE` (no grant): the *pick* transition goes to `ST_GRANT` on a select that finds a pending request.
- `ST_GRANT` (grant held): the *release* transition returns to `ST_IDLE` on adjust. The *exhaust* transition goes to `ST_SPENT` instead when that grant used the last slot of the budget.
- `ST_SPENT` (slot budget used): select and adjust are ignored.
- From any state, the *restart* transition on merge returns to `ST_IDLE`.

Top module: `ext_slot_sched`

## Requirements
- R1: After reset `grant_valid` is 0 and no request is pending, so a select made before any merge leaves `grant_valid` at 0.
- R2: On merge, controller i is read from `req_codes[2i+1:2i]`. Code 01 sets its pending bit, code 00 clears it, and codes 10 and 11 (unknown) leave it unchanged. Merge also drops `grant_valid` and restores the full slot budget.
- R3: A select in `ST_IDLE` that finds a pending request raises `grant_valid` one cycle later. `grant_idx` then holds the index chosen by the policy.
- R4: FIFO policy: the winner is the first pending index found scanning upward, with wrap, from the index register. Adjust sets the index register to the winner plus one, modulo `NCTRL`. A merge into an empty pending set resets the index register to 0.
- R5: Static-priority policy: the winner is the lowest pending index.
- R6: Priority-first policy: indices below `URGENT_CNT` form the urgent class, and the lowest pending urgent index wins. When no urgent request is pending, the remaining pending requests are scanned as in R4.
- R7: FIFO-first policy: pending requests at or above `URGENT_CNT` are scanned first, as in R4. The lowest pending urgent index wins only when none of them is pending.
- R8: Adjust while a grant is held clears that controller's pending bit and drops `grant_valid` one cycle later. Adjust while no grant is held has no effect.
- R9: A select while nothing is pending leaves `grant_valid` at 0.
- R10: At most `EXT_SLOTS` grants are made between two merges. Later selects leave `grant_valid` at 0, and the unserved requests stay pending for the next cycle.
- R11: A select while a grant is held is ignored, and `grant_idx` keeps its value.
- R12: When strobes coincide, merge takes precedence over adjust, and adjust takes precedence over select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_codes | input | 2*NCTRL | Agreed request code per controller, two bits each |
| merge_i | input | 1 | End of extension part: fold request codes into the pending set |
| select_i | input | 1 | Choose the controller for the next extension slot |
| adjust_i | input | 1 | Retire the current grant and update the index register |
| grant_idx | output | clog2(NCTRL) | Index of the granted controller |
| grant_valid | output | 1 | A grant is held |

## Verification
The hardest state to reach is one where the slot budget is used up while requests are still pending, and where those requests must then survive a merge in which every code is unknown. The stimulus reaches it with a merge that makes more requests pending than `EXT_SLOTS`, including unknown codes on controllers whose bits differ. Three select/adjust pairs exhaust the budget, a fourth select is refused, and an all-unknown merge follows. The next select must return the request that was left over. Four instances, one per policy, receive the same strobes, so the differing grant orders expose any policy mix-up.

// File: rtl/ext_slot_pkg.sv
package ext_slot_pkg;

    typedef enum logic [1:0] {
        POL_FIFO       = 2'd0,
        POL_PRIO       = 2'd1,
        POL_PRIO_FIRST = 2'd2,
        POL_FIFO_FIRST = 2'd3
    } sched_policy_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_SPENT = 2'd2
    } sched_state_e;

    // pick-network variants
    localparam int PICK_PLAIN     = 0;
    localparam int PICK_URG_FIRST = 1;
    localparam int PICK_ROT_FIRST = 2;

endpackage

// File: rtl/ext_slot_merge.sv
module ext_slot_merge #(
    parameter int NCTRL       = 8,
    parameter int IDX_W       = 3,
    parameter bit PTR_RESTART = 1'b1
) (
    input  logic [NCTRL-1:0]   pend_q,
    input  logic [IDX_W-1:0]   ptr_q,
    input  logic [2*NCTRL-1:0] req_codes,
    output logic [NCTRL-1:0]   pend_d,
    output logic [IDX_W-1:0]   ptr_d
);

    // per-controller fold: upper code bit marks an unknown entry
    for (genvar i = 0; i < NCTRL; i++) begin : g_bit
        assign pend_d[i] = req_codes[2*i+1] ? pend_q[i] : req_codes[2*i];
    end

    if (PTR_RESTART) begin : g_restart
        assign ptr_d = (pend_q == '0) ? '0 : ptr_q;
    end else begin : g_keep
        assign ptr_d = ptr_q;
    end

endmodule

// File: rtl/ext_slot_pick.sv
module ext_slot_pick #(
    parameter int NCTRL      = 8,
    parameter int IDX_W      = 3,
    parameter int URGENT_CNT = 2,
    parameter int PICK_MODE  = 0
) (
    input  logic [NCTRL-1:0] pend,
    input  logic [IDX_W-1:0] start,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    import ext_slot_pkg::*;

    // returns {found, index} of first set bit scanning upward from start
    function automatic logic [IDX_W:0] scan_from(input logic [NCTRL-1:0] vec,
                                                 input logic [IDX_W-1:0] from);
        logic [IDX_W:0] res;
        int pos;
        res = '0;
        for (int k = NCTRL - 1; k >= 0; k--) begin
            pos = int'(from) + k;
            if (pos >= NCTRL) pos = pos - NCTRL;
            if (vec[pos]) res = {1'b1, IDX_W'(pos)};
        end
        return res;
    endfunction

    if (PICK_MODE == PICK_PLAIN) begin : g_plain
        assign {hit, idx} = scan_from(pend, start);
    end else begin : g_split
        logic [NCTRL-1:0] urg_mask;
        logic [IDX_W:0]   urg_res;
        logic [IDX_W:0]   rot_res;

        for (genvar i = 0; i < NCTRL; i++) begin : g_mask
            assign urg_mask[i] = (i < URGENT_CNT);
        end

        always_comb begin
            urg_res = scan_from(pend & urg_mask, '0);
            rot_res = scan_from(pend & ~urg_mask, start);
        end

        if (PICK_MODE == PICK_URG_FIRST) begin : g_urg
            assign {hit, idx} = urg_res[IDX_W] ? urg_res : rot_res;
        end else begin : g_rot
            assign {hit, idx} = rot_res[IDX_W] ? rot_res : urg_res;
        end
    end

endmodule

// File: rtl/ext_slot_sched.sv
module ext_slot_sched #(
    parameter int NCTRL      = 8,
    parameter int EXT_SLOTS  = 3,
    parameter int URGENT_CNT = 2,
    parameter ext_slot_pkg::sched_policy_e POLICY = ext_slot_pkg::POL_FIFO
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [2*NCTRL-1:0]                        req_codes,
    input  logic                                      merge_i,
    input  logic                                      select_i,
    input  logic                                      adjust_i,
    output logic [((NCTRL > 1) ? $clog2(NCTRL) : 1)-1:0] grant_idx,
    output logic                                      grant_valid
);
    import ext_slot_pkg::*;

    localparam int IDX_W     = (NCTRL > 1) ? $clog2(NCTRL) : 1;
    localparam int CNT_W     = $clog2(EXT_SLOTS + 1);
    localparam bit USE_PTR   = (POLICY != POL_PRIO);
    localparam int PICK_MODE = (POLICY == POL_PRIO_FIRST) ? PICK_URG_FIRST :
                               (POLICY == POL_FIFO_FIRST) ? PICK_ROT_FIRST : PICK_PLAIN;

    sched_state_e     state_q, state_d;
    logic [NCTRL-1:0] pend_q, pend_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] gidx_q, gidx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic [NCTRL-1:0] mrg_pend;
    logic [IDX_W-1:0] mrg_ptr;
    logic [IDX_W-1:0] pick_start;
    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;

    assign pick_start = USE_PTR ? ptr_q : '0;

    ext_slot_merge #(
        .NCTRL      (NCTRL),
        .IDX_W      (IDX_W),
        .PTR_RESTART(USE_PTR)
    ) u_merge (
        .pend_q   (pend_q),
        .ptr_q    (ptr_q),
        .req_codes(req_codes),
        .pend_d   (mrg_pend),
        .ptr_d    (mrg_ptr)
    );

    ext_slot_pick #(
        .NCTRL     (NCTRL),
        .IDX_W     (IDX_W),
        .URGENT_CNT(URGENT_CNT),
        .PICK_MODE (PICK_MODE)
    ) u_pick (
        .pend (pend_q),
        .start(pick_start),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    // next-state logic; merge outranks adjust, adjust outranks select
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        ptr_d   = ptr_q;
        gidx_d  = gidx_q;
        cnt_d   = cnt_q;
        if (merge_i) begin
            pend_d  = mrg_pend;
            ptr_d   = mrg_ptr;
            cnt_d   = '0;
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (select_i && pick_hit) begin
                        state_d = ST_GRANT;
                        gidx_d  = pick_idx;
                        cnt_d   = cnt_q + CNT_W'(1);
                    end
                end
                ST_GRANT: begin
                    if (adjust_i) begin
                        pend_d[gidx_q] = 1'b0;
                        ptr_d   = (gidx_q == IDX_W'(NCTRL - 1)) ? '0 : gidx_q + IDX_W'(1);
                        state_d = (cnt_q == CNT_W'(EXT_SLOTS)) ? ST_SPENT : ST_IDLE;
                    end
                end
                ST_SPENT: begin
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            ptr_q   <= '0;
            gidx_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            ptr_q   <= ptr_d;
            gidx_q  <= gidx_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        grant_valid = (state_q == ST_GRANT);
        grant_idx   = gidx_q;
    end

    // R3: a held grant always belongs to a pending controller
    p_valid_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pend_q[grant_idx]);

    // R8: adjust retires the granted request
    p_adjust_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && adjust_i && !merge_i) |=> (!grant_valid && !pend_q[$past(grant_idx)]));

    // R2: merge drops any grant
    p_merge_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |=> !grant_valid);

    // R10: grant counter never exceeds the slot budget
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(EXT_SLOTS));

    // R11: select during a held grant keeps the grant
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && select_i && !adjust_i && !merge_i) |=> (grant_valid && $stable(grant_idx)));

    // R9: nothing pending gives no grant
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && select_i && !merge_i && pend_q == '0) |=> !grant_valid);

    // R2: unknown codes leave the pending bit alone
    for (genvar i = 0; i < NCTRL; i++) begin : g_unknown_chk
        p_unknown_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (merge_i && req_codes[2*i+1]) |=> (pend_q[i] == $past(pend_q[i])));
    end

    // R5: static priority grants the lowest pending index
    if (POLICY == POL_PRIO) begin : g_prio_chk
        logic [NCTRL-1:0] below_mask;
        always_comb begin
            for (int i = 0; i < NCTRL; i++) below_mask[i] = (i < int'(grant_idx));
        end
        p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |-> ((pend_q & below_mask) == '0));
    end

endmodule

// File: tb/ext_slot_sched_bench.sv
module ext_slot_sched_bench;
    import ext_slot_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_codes = '0;
    logic        merge_i = 1'b0;
    logic        select_i = 1'b0;
    logic        adjust_i = 1'b0;

    logic [2:0]  gi [4];
    logic        gv [4];

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    ext_slot_sched #(.POLICY(POL_FIFO)) u_ext_slot_sched (
        .clk(clk), .rst_n(rst_n), .req_codes(req_codes), .merge_i(merge_i),
        .select_i(select_i), .adjust_i(adjust_i), .grant_idx(gi[0]), .grant_valid(gv[0]));
    ext_slot_sched #(.POLICY(POL_PRIO)) u_ext_slot_sched_prio (
        .clk(clk), .rst_n(rst_n), .req_codes(req_codes), .merge_i(merge_i),
        .select_i(select_i), .adjust_i(adjust_i), .grant_idx(gi[1]), .grant_valid(gv[1]));
    ext_slot_sched #(.POLICY(POL_PRIO_FIRST)) u_ext_slot_sched_pf (
        .clk(clk), .rst_n(rst_n), .req_codes(req_codes), .merge_i(merge_i),
        .select_i(select_i), .adjust_i(adjust_i), .grant_idx(gi[2]), .grant_valid(gv[2]));
    ext_slot_sched #(.POLICY(POL_FIFO_FIRST)) u_ext_slot_sched_ff (
        .clk(clk), .rst_n(rst_n), .req_codes(req_codes), .merge_i(merge_i),
        .select_i(select_i), .adjust_i(adjust_i), .grant_idx(gi[3]), .grant_valid(gv[3]));

    // entry: {op[2], tag[4], codes[16], valid{d3..d0}[4], idx{d3..d0}[12]}
    // op 0 merge, 1 select, 2 adjust; d0 FIFO, d1 priority, d2 priority-first, d3 FIFO-first
    localparam int NENT = 24;
    localparam logic [37:0] TBL [NENT] = '{
        {2'd0, 4'd2,  16'h1044, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd3, 3'd1, 3'd1, 3'd1},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd6, 3'd3, 3'd3, 3'd3},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd1, 3'd6, 3'd6, 3'd6},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd0, 4'd2,  16'h4401, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd5, 3'd0, 3'd0, 3'd0},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd7, 3'd5, 3'd5, 3'd5},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd0, 4'd2,  16'h8116, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd2, 3'd1, 3'd1, 3'd7},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd4, 3'd2, 3'd2, 3'd1},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd3,  16'h0000, 4'b1111, 3'd0, 3'd4, 3'd4, 3'd2},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd10, 16'h0000, 4'b0000, 12'd0},
        {2'd0, 4'd2,  16'hAAAA, 4'b0000, 12'd0},
        {2'd1, 4'd2,  16'h0000, 4'b1111, 3'd1, 3'd7, 3'd7, 3'd4},
        {2'd2, 4'd8,  16'h0000, 4'b0000, 12'd0},
        {2'd1, 4'd9,  16'h0000, 4'b0000, 12'd0}
    };

    function automatic string tag_name(input logic [3:0] t, input int d);
        case (t)
            4'd2:    return "R2";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: begin
                case (d)
                    0:       return "R3/R4";
                    1:       return "R3/R5";
                    2:       return "R3/R6";
                    default: return "R3/R7";
                endcase
            end
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic op(input logic m, input logic s, input logic a, input logic [15:0] codes);
        @(negedge clk);
        merge_i   = m;
        select_i  = s;
        adjust_i  = a;
        req_codes = codes;
        @(negedge clk);
        merge_i   = 1'b0;
        select_i  = 1'b0;
        adjust_i  = 1'b0;
        req_codes = '0;
    endtask

    task automatic chk_all_valid(input string tag, input logic exp);
        for (int d = 0; d < 4; d++) chk(tag, int'(gv[d]), int'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all_valid("R1", 1'b0);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk_all_valid("R1", 1'b0);

        // table walk, same strobes on all four policies
        for (int n = 0; n < NENT; n++) begin
            logic [37:0] ent;
            ent = TBL[n];
            op(ent[37:36] == 2'd0, ent[37:36] == 2'd1, ent[37:36] == 2'd2, ent[31:16]);
            for (int d = 0; d < 4; d++) begin
                chk(tag_name(ent[35:32], d), int'(gv[d]), int'(ent[12+d]));
                if (ent[12+d]) chk(tag_name(ent[35:32], d), int'(gi[d]), int'(ent[3*d +: 3]));
            end
        end

        // R1: reset in mid-run discards pending requests
        op(1'b1, 1'b0, 1'b0, 16'h1044);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk_all_valid("R1", 1'b0);

        // R11: select while grant held (FIFO instance)
        op(1'b1, 1'b0, 1'b0, 16'h1044);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R11", int'(gi[0]), 1);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R11", int'(gv[0]), 1);
        chk("R11", int'(gi[0]), 1);
        op(1'b0, 1'b0, 1'b1, 16'h0000);

        // R12: merge beats select, adjust beats select
        op(1'b1, 1'b1, 1'b0, 16'h1044);
        chk_all_valid("R12", 1'b0);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R12", int'(gv[0]), 1);
        chk("R4", int'(gi[0]), 3);
        op(1'b0, 1'b1, 1'b1, 16'h0000);
        chk("R12", int'(gv[0]), 0);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R4", int'(gi[0]), 6);
        op(1'b0, 1'b0, 1'b1, 16'h0000);

        // R8: adjust with no grant held leaves controller 1 pending
        op(1'b0, 1'b0, 1'b1, 16'h0000);
        chk("R8", int'(gv[0]), 0);
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        chk("R8", int'(gv[0]), 1);
        chk("R8", int'(gi[0]), 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule